// File: doc/BRIEF.md
# Qualified Falling-Edge Event Down-Counter

This block counts high-to-low transitions on an asynchronous count pin and counts down from a value the host loads. The pin is typically strapped to a bus line that pulses once per block or once per byte. The strap is chosen outside the block.

The host drives three strobes: a command write, a data write and a data read. An arming command selects what the next data access does. Command E2h arms a write of the initial count. Command E3h arms a read of the live count. Command F4h copies the initial count into the counter and starts counting.

Before an edge counts, it must pass a width filter. The pin is first brought into the clock domain with two flops. A falling edge then counts only if the pin stayed high for at least `HIGH_MIN` clocks and then stayed low for at least `LOW_MIN` clocks. When the count reaches zero, the block raises a level flag for the interrupt logic and stops.

Top module: `evt_down_counter`

## Requirements
- R1: After reset the done flag is 0, `rd_valid_o` is 0, the live count reads 00h and no edge is counted until a start command.
- R2: A data write that directly follows command E2h stores `wr_data_i` as the initial count. A data write with no pending E2h is ignored and leaves the stored initial count unchanged.
- R3: Command F4h loads the counter from the initial count and enables counting. An initial count of 00h means 256 edges, and any other value N means N edges.
- R4: Each qualified falling edge lowers an enabled counter by exactly one. The count never changes in any other way except through a start command.
- R5: A low phase shorter than `LOW_MIN` clocks after the synchronizer is not counted.
- R6: A falling edge that follows a high phase shorter than `HIGH_MIN` clocks is not counted.
- R7: When the count reaches zero, `evt_done_o` goes to 1, the counter holds zero and further edges are ignored until the next start.
- R8: `evt_done_o` is cleared by a write of the initial count or by a start command.
- R9: A data read strobe that directly follows command E3h gives `rd_valid_o` = 1 for one cycle on the next clock, with the low 8 bits of the live count on `rd_data_o`. A read strobe with no pending E3h gives no `rd_valid_o`. Each arming command serves only one data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_pin_i | input | 1 | Asynchronous count input |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command code |
| data_we_i | input | 1 | Data write strobe |
| data_i | input | CNT_W | Data written by the host |
| data_re_i | input | 1 | Data read strobe |
| rd_data_o | output | CNT_W | Read data |
| rd_valid_o | output | 1 | Read data valid, one cycle |
| evt_done_o | output | 1 | Count reached zero |

## Verification
The count pin is driven with three kinds of pulse trains:
- Pulses that are wide in both phases, which must each lower the count by one.
- Pulses with a short low phase, which tell apart a filter that qualifies the low width from one that counts the raw edge.
- Pulses with a short high phase before the fall, which tell apart a filter that also checks the preceding high width.

A full 256-edge run from a loaded 00h separates the 256-count encoding from an immediate stop. Extra edges after zero show whether the counter holds at zero or wraps. Unarmed reads and writes show that each data access is gated by its own command.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam logic [7:0] CMD_WR_INIT = 8'hE2;
  localparam logic [7:0] CMD_RD_CNT  = 8'hE3;
  localparam logic [7:0] CMD_START   = 8'hF4;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_WR   = 2'd1,
    ARM_RD   = 2'd2
  } arm_e;
endpackage

// File: rtl/evt_pulse_qual.sv
module evt_pulse_qual #(
  parameter int HIGH_MIN = 50,
  parameter int LOW_MIN  = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic tick_o
);
  localparam int RUN_MAX = (HIGH_MIN > LOW_MIN) ? HIGH_MIN : LOW_MIN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] HI_REQ  = RUN_W'(HIGH_MIN);
  localparam logic [RUN_W-1:0] LO_REQ  = RUN_W'(LOW_MIN);

  logic [1:0]       sync_q;
  logic             lvl, prev_q, armed_q;
  logic [RUN_W-1:0] run_q;

  assign lvl    = sync_q[1];
  assign tick_o = armed_q && !prev_q && !lvl && (run_q >= LO_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= lvl;
      if (lvl != prev_q)       run_q <= RUN_W'(1);
      else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
      // arm on a fall only after a long enough high phase
      if (prev_q && !lvl)       armed_q <= (run_q >= HI_REQ);
      else if (lvl || tick_o)   armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_cmd_decode.sv
module evt_cmd_decode
  import evt_ctr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] cmd_i,
  input  logic       data_we_i,
  input  logic       data_re_i,
  output logic       load_o,
  output logic       start_o,
  output logic       rd_o
);
  arm_e arm_q, arm_d;

  always_comb begin
    arm_d   = arm_q;
    load_o  = 1'b0;
    start_o = 1'b0;
    rd_o    = 1'b0;
    if (cmd_we_i) begin
      unique case (cmd_i)
        CMD_WR_INIT: arm_d = ARM_WR;
        CMD_RD_CNT:  arm_d = ARM_RD;
        CMD_START: begin
          arm_d   = ARM_NONE;
          start_o = 1'b1;
        end
        default:     arm_d = ARM_NONE;
      endcase
    end else if (data_we_i && arm_q == ARM_WR) begin
      load_o = 1'b1;
      arm_d  = ARM_NONE;
    end else if (data_re_i && arm_q == ARM_RD) begin
      rd_o  = 1'b1;
      arm_d = ARM_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= ARM_NONE;
    else         arm_q <= arm_d;
  end
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             start_i,
  input  logic             tick_i,
  output logic [CNT_W:0]   cnt_o,
  output logic             en_o,
  output logic             done_o
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W-1:0] init_q;
  logic [CNT_W:0]   cnt_q;
  logic             en_q, done_q;

  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load_i) begin
        init_q <= data_i;
        done_q <= 1'b0;
      end
      if (start_i) begin
        // zero initial value encodes the full 2**CNT_W range
        cnt_q  <= (init_q == '0) ? FULL : {1'b0, init_q};
        en_q   <= 1'b1;
        done_q <= 1'b0;
      end else if (en_q && tick_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == (CNT_W+1)'(1)) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter #(
  parameter int CNT_W    = 8,
  parameter int HIGH_MIN = 50,
  parameter int LOW_MIN  = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_pin_i,
  input  logic             cmd_we_i,
  input  logic [7:0]       cmd_i,
  input  logic             data_we_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             data_re_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             evt_done_o
);
  logic           tick_w, load_w, start_w, rd_w, en_w;
  logic [CNT_W:0] cnt_w;

  evt_pulse_qual #(.HIGH_MIN(HIGH_MIN), .LOW_MIN(LOW_MIN)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (cnt_pin_i),
    .tick_o(tick_w)
  );

  evt_cmd_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (cmd_we_i),
    .cmd_i    (cmd_i),
    .data_we_i(data_we_i),
    .data_re_i(data_re_i),
    .load_o   (load_w),
    .start_o  (start_w),
    .rd_o     (rd_w)
  );

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .data_i (data_i),
    .start_i(start_w),
    .tick_i (tick_w),
    .cnt_o  (cnt_w),
    .en_o   (en_w),
    .done_o (evt_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_w;
      if (rd_w) rd_data_o <= cnt_w[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/evt_down_counter_chk.sv
module evt_down_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [CNT_W:0] cnt_w,
  input logic           start_w,
  input logic           load_w,
  input logic           rd_w,
  input logic           en_w,
  input logic           evt_done_o,
  input logic           rd_valid_o
);
  p_done_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_done_o |-> cnt_w == '0);

  p_hold_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == '0 && !start_w) |=> cnt_w == '0);

  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w != $past(cnt_w) && !$past(start_w)) |-> cnt_w == $past(cnt_w) - 1'b1);

  p_idle_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_w && !start_w) |=> $stable(cnt_w));

  p_done_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w || load_w) |=> !evt_done_o);

  p_rd_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_w));
endmodule

bind evt_down_counter evt_down_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_w     (cnt_w),
  .start_w   (start_w),
  .load_w    (load_w),
  .rd_w      (rd_w),
  .en_w      (en_w),
  .evt_done_o(evt_done_o),
  .rd_valid_o(rd_valid_o)
);

// File: tb/evt_down_counter_bench.sv
module evt_down_counter_bench;
  localparam int CNT_W = 8;
  localparam int HMIN  = 4;
  localparam int LMIN  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cnt_pin = 1'b1, cmd_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0] cmd = '0;
  logic [CNT_W-1:0] data = '0, rd_data;
  logic rd_valid, done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  evt_down_counter #(.CNT_W(CNT_W), .HIGH_MIN(HMIN), .LOW_MIN(LMIN)) u_evt_down_counter (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_pin_i(cnt_pin), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .data_we_i(data_we), .data_i(data), .data_re_i(data_re),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .evt_done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic write_data(input logic [7:0] d);
    @(negedge clk); data_we = 1'b1; data = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic load_init(input logic [7:0] d);
    send_cmd(8'hE2); write_data(d);
  endtask

  // returns count; rd_valid sampled one cycle after strobe
  task automatic read_cnt(output int v, output int vld);
    send_cmd(8'hE3);
    data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
    v = rd_data; vld = rd_valid;
    @(negedge clk);
  endtask

  task automatic pulse(input int lo, input int hi);
    @(negedge clk); cnt_pin = 1'b0;
    repeat (lo) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic t_reset();
    int v, vld;
    check("R1 done after reset", done, 0);
    check("R1 rd_valid after reset", rd_valid, 0);
    pulse(12, 8);
    read_cnt(v, vld);
    check("R1 count after reset", v, 0);
    check("R1 read valid", vld, 1);
  endtask

  task automatic t_basic();
    int v, vld;
    load_init(8'd5);
    send_cmd(8'hF4);
    read_cnt(v, vld);
    check("R3 start loads 5", v, 5);
    repeat (3) pulse(12, 8);
    read_cnt(v, vld);
    check("R4 three edges", v, 2);
    check("R4 no done yet", done, 0);
  endtask

  task automatic t_narrow_low();
    int v, vld;
    repeat (2) pulse(4, 8);
    read_cnt(v, vld);
    check("R5 short low ignored", v, 2);
  endtask

  task automatic t_narrow_high();
    int v, vld;
    pulse(12, 2);
    pulse(12, 8);
    read_cnt(v, vld);
    check("R6 short high ignored", v, 1);
  endtask

  task automatic t_zero_hold();
    int v, vld;
    pulse(12, 8);
    check("R7 done at zero", done, 1);
    repeat (2) pulse(12, 8);
    read_cnt(v, vld);
    check("R7 holds zero", v, 0);
    check("R7 done held", done, 1);
  endtask

  task automatic t_done_clear();
    load_init(8'd2);
    check("R8 init write clears done", done, 0);
    send_cmd(8'hF4);
    repeat (2) pulse(12, 8);
    check("R8 done again", done, 1);
    send_cmd(8'hF4);
    check("R8 start clears done", done, 0);
  endtask

  task automatic t_unarmed();
    int v, vld;
    write_data(8'd9);
    send_cmd(8'hF4);
    read_cnt(v, vld);
    check("R2 unarmed write ignored", v, 2);
    @(negedge clk); data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
    check("R9 unarmed read no valid", rd_valid, 0);
    send_cmd(8'hE3);
    data_re = 1'b1;
    @(negedge clk);
    check("R9 armed read valid", rd_valid, 1);
    check("R9 armed read data", rd_data, 2);
    @(negedge clk); data_re = 1'b0;
    check("R9 arm used once", rd_valid, 0);
  endtask

  task automatic t_full_range();
    int v, vld;
    load_init(8'h00);
    send_cmd(8'hF4);
    repeat (255) pulse(12, 8);
    read_cnt(v, vld);
    check("R3 00h after 255 edges", v, 1);
    check("R3 not done at 255", done, 0);
    pulse(12, 8);
    read_cnt(v, vld);
    check("R3 zero after 256", v, 0);
    check("R3 done after 256", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_narrow_low();
    t_narrow_high();
    t_zero_hold();
    t_done_clear();
    t_unarmed();
    t_full_range();
    finish_sim();
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end
endmodule